// File: doc/BRIEF.md
# UART Modem Status Tracker

This block watches the four active-low modem input lines of a serial port: clear-to-send, data-set-ready, ring indicator and carrier detect. It presents them in a read-only status word. The upper nibble of the low byte shows the present level of each line as an active-high bit. The lower nibble holds sticky change flags. Three of these flags catch any change on their line. The ring flag catches only the moment the ring signal ends. A read strobe from the register decoder clears all four flags.

External inputs pass through a synchronizer before any edge is detected. For self-test, a loopback enable replaces the pins with four modem-control output bits. In that mode the status levels and the change flags follow those control bits. While the interrupt enable is high, a modem-status interrupt request is raised whenever a change flag is set.

After any reset the remembered line levels start in the deasserted state. A line that is still asserted when reset is released therefore produces its change flag at once.

Top module: `modem_status_unit`

## Requirements
- R1: Status bits 7, 6, 5 and 4 show carrier detect, ring, data-set-ready and clear-to-send. Each bit is the inverse of its low-active pin. A pin change shows in the status word after the third rising clock edge that follows it.
- R2: Bits 3, 1 and 0 are change flags for carrier detect, data-set-ready and clear-to-send. A flag sets at the edge where its line's level changes, in either direction. It then stays set until it is cleared.
- R3: Bit 2 sets only when the ring level goes from asserted to deasserted. Assertion of ring leaves bit 2 unchanged.
- R4: A cycle with rd_stb high returns the flags as they are, and clears all four flags at that clock edge.
- R5: With loop_en high, the line sources are mctl bits, and a change shows one edge later. Carrier detect follows mctl[3], ring follows mctl[2], data-set-ready follows mctl[0] and clear-to-send follows mctl[1]. The external pins have no effect on the status word. With loop_en low, mctl has no effect.
- R6: In loopback, bit 2 sets when mctl[2] falls from 1 to 0. It does not set when mctl[2] rises.
- R7: After reset is released, each of carrier detect, data-set-ready and clear-to-send that is still asserted sets its change flag. Ring held asserted through reset sets no flag.
- R8: During reset the status word reads 0. Bits WORD_W-1 down to 8 always read 0.
- R9: If a line change and a read strobe fall on the same edge, the flag of that line ends up set. The other flags are cleared.
- R10: irq is high exactly when irq_en is high and at least one change flag is set.
- R11: Turning loopback on or off is treated as a source change. It sets the change flag of every line whose selected level differs from its previous level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cts_in_n | input | 1 | Clear-to-send pin, active low |
| dsr_in_n | input | 1 | Data-set-ready pin, active low |
| ri_in_n | input | 1 | Ring indicator pin, active low |
| dcd_in_n | input | 1 | Carrier detect pin, active low |
| mctl | input | 4 | Modem-control outputs: bit0 DTR, bit1 RTS, bit2 OUT1, bit3 OUT2 |
| loop_en | input | 1 | Loopback select |
| irq_en | input | 1 | Modem-status interrupt enable |
| rd_stb | input | 1 | Status-register read strobe |
| stat_word | output | WORD_W | Status word (levels in 7..4, flags in 3..0) |
| irq | output | 1 | Modem-status interrupt request |

## Verification
The bench aims at the ring flag on both kinds of edge, in normal mode and in loopback. A design that sets it on any change would flag the ring assertion. The bench also lines up a flag-setting change with a read strobe on the same edge. A design that lets the clear win would lose that event.

Two resets are held with lines asserted, to check the flags that follow release. Restoring the previous-level register to the live level would leave those flags clear. The bench also flips loopback while the selected levels differ, and checks that mctl has no effect outside loopback and that the pins have no effect inside it. A swapped source mapping shows up as a wrong bit in the status word.

// File: rtl/msu_pkg.sv
`timescale 1ns/1ps
package msu_pkg;

   localparam int LINES = 4;

   // Line index: status level bit = 4 + index, change flag bit = index.
   typedef enum logic [1:0] {
      LN_CTS = 2'd0,
      LN_DSR = 2'd1,
      LN_RING = 2'd2,
      LN_CARR = 2'd3
   } line_e;

   typedef enum logic {
      EDGE_ANY  = 1'b0,
      EDGE_FALL = 1'b1
   } edge_e;

   // Which change of the active-high level raises the flag of a line.
   function automatic edge_e edge_kind(input int idx);
      return (idx == int'(LN_RING)) ? EDGE_FALL : EDGE_ANY;
   endfunction

   // Modem-control bit that feeds a line in loopback.
   function automatic int ctl_index(input int idx);
      case (idx)
         int'(LN_CTS):  return 1; // RTS
         int'(LN_DSR):  return 0; // DTR
         int'(LN_RING): return 2; // OUT1
         default:       return 3; // OUT2
      endcase
   endfunction

endpackage

// File: rtl/msu_sync.sv
`timescale 1ns/1ps
module msu_sync #(
   parameter int          WIDTH   = 4,
   parameter int          STAGES  = 2,
   parameter logic        RST_VAL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("msu_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("msu_sync: WIDTH must be positive");
      end
   endgenerate

   logic [WIDTH-1:0] chain_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) chain_q[s] <= {WIDTH{RST_VAL}};
      end else begin
         chain_q[0] <= d;
         for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
      end
   end

   assign q = chain_q[STAGES-1];

endmodule

// File: rtl/msu_src_sel.sv
`timescale 1ns/1ps
module msu_src_sel
   import msu_pkg::*;
#(
   parameter int NLINES = LINES
) (
   input  logic              loop_en,
   input  logic [NLINES-1:0] pin_act,
   input  logic [3:0]        mctl,
   output logic [NLINES-1:0] src
);

   generate
      if (NLINES != LINES) begin : g_bad_lines
         $error("msu_src_sel: NLINES must match the package line count");
      end
      for (genvar i = 0; i < NLINES; i++) begin : g_line
         localparam int CI = ctl_index(i);
         assign src[i] = loop_en ? mctl[CI] : pin_act[i];
      end
   endgenerate

endmodule

// File: rtl/msu_delta.sv
`timescale 1ns/1ps
module msu_delta
   import msu_pkg::*;
#(
   parameter edge_e KIND = EDGE_ANY
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cur,
   input  logic rd_clr,
   output logic lvl_q,
   output logic flag_q
);

   logic hit;

   generate
      if (KIND == EDGE_FALL) begin : g_fall
         assign hit = lvl_q & ~cur;
      end else begin : g_any
         assign hit = lvl_q ^ cur;
      end
   endgenerate

   // Previous level resets to deasserted, so a line held asserted
   // through reset produces its flag once released.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q  <= 1'b0;
         flag_q <= 1'b0;
      end else begin
         lvl_q <= cur;
         if (hit)         flag_q <= 1'b1;
         else if (rd_clr) flag_q <= 1'b0;
      end
   end

   // R2: an unread flag stays set
   a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !rd_clr) |=> flag_q);

   // R4: a read with no change on this line clears the flag
   a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clr && (lvl_q == cur)) |=> !flag_q);

   generate
      if (KIND == EDGE_FALL) begin : g_chk_fall
         // R3: the ring flag only rises on a 1 -> 0 level step
         a_r3_fall_only: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flag_q) |-> ($past(lvl_q) && !lvl_q));
         // R9: a falling step wins over a read on the same edge
         a_r9_set_wins_fall: assert property (@(posedge clk) disable iff (!rst_n)
            (lvl_q && !cur) |=> flag_q);
      end else begin : g_chk_any
         // R9: any step wins over a read on the same edge
         a_r9_set_wins_any: assert property (@(posedge clk) disable iff (!rst_n)
            (lvl_q != cur) |=> flag_q);
      end
   endgenerate

endmodule

// File: rtl/modem_status_unit.sv
`timescale 1ns/1ps
module modem_status_unit
   import msu_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int WORD_W      = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cts_in_n,
   input  logic              dsr_in_n,
   input  logic              ri_in_n,
   input  logic              dcd_in_n,
   input  logic [3:0]        mctl,
   input  logic              loop_en,
   input  logic              irq_en,
   input  logic              rd_stb,
   output logic [WORD_W-1:0] stat_word,
   output logic              irq
);

   localparam int LVL_LSB = LINES;
   localparam int USED_W  = 2 * LINES;

   generate
      if (WORD_W < USED_W) begin : g_bad_word
         $error("modem_status_unit: WORD_W must hold the status byte");
      end
   endgenerate

   logic [LINES-1:0] pins_n, pins_sync_n, pin_act, src, lvl, flg;

   always_comb begin
      pins_n            = '0;
      pins_n[LN_CTS]    = cts_in_n;
      pins_n[LN_DSR]    = dsr_in_n;
      pins_n[LN_RING]   = ri_in_n;
      pins_n[LN_CARR]   = dcd_in_n;
   end

   msu_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pins_n),
      .q     (pins_sync_n)
   );

   assign pin_act = ~pins_sync_n;

   msu_src_sel #(.NLINES(LINES)) u_sel (
      .loop_en (loop_en),
      .pin_act (pin_act),
      .mctl    (mctl),
      .src     (src)
   );

   generate
      for (genvar i = 0; i < LINES; i++) begin : g_trk
         msu_delta #(.KIND(edge_kind(i))) u_delta (
            .clk    (clk),
            .rst_n  (rst_n),
            .cur    (src[i]),
            .rd_clr (rd_stb),
            .lvl_q  (lvl[i]),
            .flag_q (flg[i])
         );
      end
      if (WORD_W > USED_W) begin : g_pad
         assign stat_word[WORD_W-1:USED_W] = '0;
      end
   endgenerate

   assign stat_word[USED_W-1:LVL_LSB] = lvl;
   assign stat_word[LVL_LSB-1:0]      = flg;
   assign irq = irq_en & (|flg);

   // R10: no request while the enable is low
   a_r10_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en |-> !irq);

   // R10: a raised request always has a pending flag behind it
   a_r10_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (stat_word[LVL_LSB-1:0] != '0));

   // R5: in steady loopback the carrier and ring levels track OUT2 and OUT1
   a_r5_loop_carr: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(loop_en)) |-> (stat_word[LVL_LSB + 3] == $past(mctl[3])));
   a_r5_loop_ring: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(loop_en)) |-> (stat_word[LVL_LSB + 2] == $past(mctl[2])));

endmodule

// File: tb/tb_modem_status_unit.sv
`timescale 1ns/1ps
module tb_modem_status_unit;

   localparam int WW = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cts_n = 1'b1, dsr_n = 1'b1, ri_n = 1'b1, dcd_n = 1'b1;
   logic [3:0] mctl = 4'h0;
   logic loop_en = 1'b0, irq_en = 1'b1, rd_stb = 1'b0;
   logic [WW-1:0] stat_word;
   logic irq;

   int cyc = 0;
   int checks = 0;
   int errors = 0;

   typedef struct {
      int         due;
      logic [7:0] val;
      logic       irq;
      string      tag;
   } exp_t;

   exp_t sb[$];

   always #4 clk = ~clk;

   always @(posedge clk) begin
      if (!rst_n) cyc <= 0;
      else        cyc <= cyc + 1;
   end

   modem_status_unit #(.SYNC_STAGES(2), .WORD_W(WW)) dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .cts_in_n  (cts_n),
      .dsr_in_n  (dsr_n),
      .ri_in_n   (ri_n),
      .dcd_in_n  (dcd_n),
      .mctl      (mctl),
      .loop_en   (loop_en),
      .irq_en    (irq_en),
      .rd_stb    (rd_stb),
      .stat_word (stat_word),
      .irq       (irq)
   );

   task automatic push(input int due, input logic [7:0] v, input string tag);
      exp_t e;
      e.due = due;
      e.val = v;
      e.irq = irq_en && (v[3:0] != 4'h0);
      e.tag = tag;
      sb.push_back(e);
   endtask

   task automatic drain();
      while (sb.size() != 0) @(negedge clk);
   endtask

   // Read pulse: flags clear at the edge the strobe is sampled.
   task automatic read_pulse(input logic [7:0] v, input string tag);
      int t;
      rd_stb = 1'b1;
      t = cyc;
      @(negedge clk);
      rd_stb = 1'b0;
      push(t + 1, v, tag);
      drain();
   endtask

   // Monitor: samples between the falling and the next rising edge.
   always @(negedge clk) begin
      #2;
      while (sb.size() != 0 && sb[0].due <= cyc) begin
         exp_t e;
         e = sb.pop_front();
         checks++;
         if (e.due != cyc) begin
            errors++;
            $display("FAIL %s: missed sample at cycle %0d (now %0d)", e.tag, e.due, cyc);
         end else if (stat_word !== {{(WW-8){1'b0}}, e.val} || irq !== e.irq) begin
            errors++;
            $display("FAIL %s: got word %h irq %b, expected word %h irq %b",
                     e.tag, stat_word, irq, {{(WW-8){1'b0}}, e.val}, e.irq);
         end
      end
   end

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int t;
      cts_n = 1'b0;
      repeat (3) @(negedge clk);
      push(cyc, 8'h00, "R8 reset state");
      drain();
      rst_n = 1'b1;
      t = cyc;
      push(t + 2, 8'h00, "R1 sync latency not yet");
      push(t + 3, 8'h11, "R7 cts held through reset");
      drain();
      read_pulse(8'h10, "R4 read clears flags");

      cts_n = 1'b1; t = cyc;
      push(t + 3, 8'h01, "R2 cts deassert flags");
      drain();
      read_pulse(8'h00, "R4 clear after cts");

      dsr_n = 1'b0; dcd_n = 1'b0; t = cyc;
      push(t + 3, 8'hAA, "R1 R2 dsr and carrier assert");
      drain();
      read_pulse(8'hA0, "R4 clear after dsr/carrier");

      ri_n = 1'b0; t = cyc;
      push(t + 3, 8'hE0, "R3 ring assert sets no flag");
      drain();
      ri_n = 1'b1; t = cyc;
      push(t + 3, 8'hA4, "R3 ring trailing edge");
      drain();
      read_pulse(8'hA0, "R4 clear ring flag");

      irq_en = 1'b0; dcd_n = 1'b1; t = cyc;
      push(t + 3, 8'h28, "R10 irq gated off");
      drain();
      irq_en = 1'b1; t = cyc;
      push(t, 8'h28, "R10 irq enabled");
      drain();
      read_pulse(8'h20, "R4 clear carrier flag");
      dsr_n = 1'b1; t = cyc;
      push(t + 3, 8'h02, "R2 dsr deassert");
      drain();
      read_pulse(8'h00, "R4 idle");

      mctl = 4'b0001; t = cyc;
      push(t + 3, 8'h00, "R5 mctl ignored outside loopback");
      drain();
      loop_en = 1'b1; t = cyc;
      push(t + 1, 8'h22, "R11 loopback entry flags dsr");
      drain();
      read_pulse(8'h20, "R4 clear in loopback");
      mctl = 4'b1011; t = cyc;
      push(t + 1, 8'hB9, "R5 OUT2 and RTS map to carrier and cts");
      drain();
      read_pulse(8'hB0, "R4 clear loop flags");
      cts_n = 1'b0; t = cyc;
      push(t + 3, 8'hB0, "R5 pins ignored in loopback");
      drain();
      mctl = 4'b1101; t = cyc;
      push(t + 1, 8'hE1, "R6 OUT1 rise sets no ring flag");
      drain();
      mctl = 4'b1001; rd_stb = 1'b1; t = cyc;
      @(negedge clk);
      rd_stb = 1'b0;
      push(t + 1, 8'hA4, "R9 R6 ring fall wins over read");
      drain();
      loop_en = 1'b0; t = cyc;
      push(t + 1, 8'h1F, "R11 loopback exit flags changed lines");
      drain();
      read_pulse(8'h10, "R4 clear after exit");

      rst_n = 1'b0; dsr_n = 1'b0; dcd_n = 1'b0; ri_n = 1'b0;
      @(negedge clk);
      push(cyc, 8'h00, "R8 second reset");
      drain();
      rst_n = 1'b1; t = cyc;
      push(t + 3, 8'hFB, "R7 three flags, ring none");
      drain();

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule